// File: doc/BRIEF.md
# Reset Strap Capture Controller

This block takes a set of board-level configuration straps, passes them through a short synchronizer, and latches them once, when the active-low system reset is released. The captured values are then presented as read-only configuration bits. These bits keep their value until the next system reset, whatever the strap pins do afterwards.

From the captured values the block derives several controls. It raises drive enables for two active-low processor address pins (bit 7 and bit 15). These enables cover the processor-reset window and a short hold after processor reset is released. The processor samples those pins to select non-pipelined bus operation and quick-start clock stopping. The block also produces isolate/tri-state controls for an optional graphics port and for the unused part of the memory interface in the legacy memory mode. It watches for illegal strap and configuration combinations and records them in a sticky error flag.

Top module: `strapCapture`

## Requirements
- R1: While `sysRstN` is sampled low, the outputs hold their defaults. `cfgQueueN` is 1. Every other configuration bit, both drive enables, both isolate controls and `strapError` are 0.
- R2: Each strap passes through `SYNC_STAGES` (2) flops. It is captured at the first rising clock edge where `sysRstN` is sampled high. The captured value appears on its configuration bit right after that edge. The mapping is: `strapQueueN`→`cfgQueueN`, `strapQuickStart`→`cfgQuickStart`, `strapGfxDisable`→`cfgGfxDisable`, `strapLegacyMem`→`cfgLegacyMem`, `strapFreqSel`→`cfgFreq100` (1 = 100 MHz host bus, 0 = 66 MHz), and `strapBufMode`→`cfgMobileBuf` (1 = low-power mobile buffers, 0 = desktop).
- R3: After capture, changes on the strap pins have no effect on the configuration bits until the next system reset.
- R4: `addr7DriveEn` is 1 only inside the drive window and only when the captured `cfgQueueN` is 0, which selects non-pipelined operation. With `cfgQueueN` = 1, pin 7 is never driven.
- R5: `addr15DriveEn` is 1 only inside the drive window and only when the captured `cfgQuickStart` is 1. With 0, normal stop-clock mode applies and pin 15 is never driven.
- R6: The drive window exists only after capture. It is open from the edge after `cpuRstN` is sampled low. It stays open for exactly `HOLD_CLKS` (2) clock cycles after the first edge at which `cpuRstN` is sampled high, and then closes. The same holds when `cpuRstN` is released at the same edge as `sysRstN`.
- R7: `gfxIsolate` is 1 after capture whenever `cfgGfxDisable` or `cfgLegacyMem` is 1. It therefore also covers the illegal combination of legacy mode without graphics disable.
- R8: `memIsolate` is 1 after capture exactly when `cfgLegacyMem` is 1.
- R9: `strapError` is set at the edge after an illegal combination is seen following capture. The illegal combinations are `cfgLegacyMem`=1 with `cfgGfxDisable`=0, and `cfgLegacyMem`=0 with `redirectBit`=1. Once set, the flag stays set until the next system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| sysRstN | input | 1 | System reset, active low, synchronous; its release triggers capture |
| cpuRstN | input | 1 | Processor reset, active low |
| strapQueueN | input | 1 | Queue-depth strap, 0 = non-pipelined |
| strapQuickStart | input | 1 | Quick-start strap, 1 = quick start |
| strapGfxDisable | input | 1 | Graphics-port disable strap |
| strapLegacyMem | input | 1 | Legacy memory-configuration strap |
| strapFreqSel | input | 1 | Host frequency strap, 1 = 100 MHz |
| strapBufMode | input | 1 | Host buffer strap, 1 = mobile |
| redirectBit | input | 1 | Device-select redirect configuration bit, from software |
| cfgQueueN | output | 1 | Captured queue-depth strap |
| cfgQuickStart | output | 1 | Captured quick-start strap |
| cfgGfxDisable | output | 1 | Captured graphics-disable strap |
| cfgLegacyMem | output | 1 | Captured legacy-memory strap |
| cfgFreq100 | output | 1 | Captured frequency strap |
| cfgMobileBuf | output | 1 | Captured buffer-mode strap |
| addr7DriveEn | output | 1 | Pull processor address pin 7 low |
| addr15DriveEn | output | 1 | Pull processor address pin 15 low |
| gfxIsolate | output | 1 | Tri-state/isolate the graphics port |
| memIsolate | output | 1 | Tri-state/isolate the unused memory-interface signals |
| strapError | output | 1 | Sticky illegal-combination flag |

## Verification
Strap capture and the processor-reset drive window can start in the same cycle. In that case the window has to use the values latched at that very edge. The bench provokes this by releasing `sysRstN` and `cpuRstN` at the same clock edge, chosen at random in each trial. It then expects the pin enables to follow the newly captured straps for exactly two cycles and to drop afterwards. Error detection also overlaps the drive window. Its flag is checked in the middle of the window against a reference computed from the captured straps and the redirect bit.

// File: rtl/strapPkg.sv
package strapPkg;

  typedef struct packed {
    logic queueN;
    logic quickStart;
    logic gfxDisable;
    logic legacyMem;
    logic freq100;
    logic mobileBuf;
  } strapSet_t;

  localparam int STRAP_W = $bits(strapSet_t);

  localparam strapSet_t STRAP_DEFAULT = '{
    queueN:     1'b1,
    quickStart: 1'b0,
    gfxDisable: 1'b0,
    legacyMem:  1'b0,
    freq100:    1'b0,
    mobileBuf:  1'b0
  };

  typedef struct packed {
    logic clear;
    logic capture;
    logic live;
    logic driveWindow;
  } ctrlStrobe_t;

endpackage

// File: rtl/strapCtrl.sv
module strapCtrl
  import strapPkg::*;
#(
  parameter int HOLD_CLKS = 2
) (
  input  logic        clk,
  input  logic        sysRstN,
  input  logic        cpuRstN,
  output ctrlStrobe_t strobe
);

  localparam int CNT_W = $clog2(HOLD_CLKS + 1);

  logic             sysRstQ;
  logic             cpuRstQ;
  logic             capValid;
  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    sysRstQ <= sysRstN;
    cpuRstQ <= cpuRstN;
  end

  always_ff @(posedge clk) begin
    if (!sysRstN) begin
      capValid <= 1'b0;
      holdCnt  <= '0;
    end else begin
      if (!sysRstQ) capValid <= 1'b1;
      if (!cpuRstQ) holdCnt <= CNT_W'(HOLD_CLKS);
      else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.clear       = !sysRstN;
    strobe.capture     = sysRstN && !sysRstQ;
    strobe.live        = capValid;
    strobe.driveWindow = capValid && (!cpuRstQ || (holdCnt != '0));
  end

  // R2: capture is a single-cycle event per reset release
  p_capture_once_r2: assert property (@(posedge clk) disable iff (!sysRstN)
    strobe.capture |=> !strobe.capture);

  // R6: processor reset held low after capture keeps the window open
  p_window_in_reset_r6: assert property (@(posedge clk) disable iff (!sysRstN)
    (capValid && $past(capValid) && !$past(cpuRstN)) |-> strobe.driveWindow);

  // R6: no window before capture
  p_no_window_early_r6: assert property (@(posedge clk) disable iff (!sysRstN)
    !capValid |-> !strobe.driveWindow);

endmodule

// File: rtl/strapDatapath.sv
module strapDatapath
  import strapPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  strapSet_t   strapRaw,
  input  logic        redirectIn,
  input  ctrlStrobe_t strobe,
  output strapSet_t   capCfg,
  output logic        addr7DriveEn,
  output logic        addr15DriveEn,
  output logic        gfxIsolate,
  output logic        memIsolate,
  output logic        strapError
);

  strapSet_t syncPipe [SYNC_STAGES];
  logic      illegalCombo;

  always_ff @(posedge clk) syncPipe[0] <= strapRaw;

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) syncPipe[g] <= syncPipe[g-1];
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) capCfg <= STRAP_DEFAULT;
    else if (strobe.capture) capCfg <= syncPipe[SYNC_STAGES-1];
  end

  always_comb begin
    illegalCombo = (capCfg.legacyMem && !capCfg.gfxDisable) ||
                   (!capCfg.legacyMem && redirectIn);
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) strapError <= 1'b0;
    else if (strobe.live && illegalCombo) strapError <= 1'b1;
  end

  always_comb begin
    addr7DriveEn  = strobe.driveWindow && !capCfg.queueN;
    addr15DriveEn = strobe.driveWindow && capCfg.quickStart;
    gfxIsolate    = capCfg.gfxDisable || capCfg.legacyMem;
    memIsolate    = capCfg.legacyMem;
  end

  // R3: captured bits only move on a capture or a clear
  p_cfg_stable_r3: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.capture |=> $stable(capCfg));

  // R9: error flag is sticky until system reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (strobe.clear)
    strapError |=> strapError);

endmodule

// File: rtl/strapCapture.sv
module strapCapture
  import strapPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CLKS   = 2
) (
  input  logic clk,
  input  logic sysRstN,
  input  logic cpuRstN,
  input  logic strapQueueN,
  input  logic strapQuickStart,
  input  logic strapGfxDisable,
  input  logic strapLegacyMem,
  input  logic strapFreqSel,
  input  logic strapBufMode,
  input  logic redirectBit,
  output logic cfgQueueN,
  output logic cfgQuickStart,
  output logic cfgGfxDisable,
  output logic cfgLegacyMem,
  output logic cfgFreq100,
  output logic cfgMobileBuf,
  output logic addr7DriveEn,
  output logic addr15DriveEn,
  output logic gfxIsolate,
  output logic memIsolate,
  output logic strapError
);

  ctrlStrobe_t strobe;
  strapSet_t   strapRaw;
  strapSet_t   capCfg;

  always_comb begin
    strapRaw.queueN     = strapQueueN;
    strapRaw.quickStart = strapQuickStart;
    strapRaw.gfxDisable = strapGfxDisable;
    strapRaw.legacyMem  = strapLegacyMem;
    strapRaw.freq100    = strapFreqSel;
    strapRaw.mobileBuf  = strapBufMode;
  end

  strapCtrl #(.HOLD_CLKS(HOLD_CLKS)) uCtrl (
    .clk     (clk),
    .sysRstN (sysRstN),
    .cpuRstN (cpuRstN),
    .strobe  (strobe)
  );

  strapDatapath #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk           (clk),
    .strapRaw      (strapRaw),
    .redirectIn    (redirectBit),
    .strobe        (strobe),
    .capCfg        (capCfg),
    .addr7DriveEn  (addr7DriveEn),
    .addr15DriveEn (addr15DriveEn),
    .gfxIsolate    (gfxIsolate),
    .memIsolate    (memIsolate),
    .strapError    (strapError)
  );

  assign cfgQueueN     = capCfg.queueN;
  assign cfgQuickStart = capCfg.quickStart;
  assign cfgGfxDisable = capCfg.gfxDisable;
  assign cfgLegacyMem  = capCfg.legacyMem;
  assign cfgFreq100    = capCfg.freq100;
  assign cfgMobileBuf  = capCfg.mobileBuf;

  // R4: pin 7 never pulled while pipelined mode is selected
  p_pin7_gated_r4: assert property (@(posedge clk) disable iff (!sysRstN)
    cfgQueueN |-> !addr7DriveEn);

  // R5: pin 15 never pulled in normal stop-clock mode
  p_pin15_gated_r5: assert property (@(posedge clk) disable iff (!sysRstN)
    !cfgQuickStart |-> !addr15DriveEn);

  // R7: legacy memory mode always isolates the graphics port
  p_gfx_iso_legacy_r7: assert property (@(posedge clk) disable iff (!sysRstN)
    cfgLegacyMem |-> gfxIsolate);

  // R1: nothing is driven while system reset holds
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    (!sysRstN && $past(!sysRstN)) |-> !(addr7DriveEn || addr15DriveEn || strapError));

endmodule

// File: tb/strapCapture_test.sv
module strapCapture_test;

  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic sysRstN, cpuRstN, redirectBit;
  logic [5:0] straps;  // [5]queueN [4]quick [3]gfx [2]legacy [1]freq [0]buf
  logic cfgQueueN, cfgQuickStart, cfgGfxDisable, cfgLegacyMem, cfgFreq100, cfgMobileBuf;
  logic addr7DriveEn, addr15DriveEn, gfxIsolate, memIsolate, strapError;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strapCapture #(.SYNC_STAGES(2), .HOLD_CLKS(HOLD)) uut (
    .clk(clk), .sysRstN(sysRstN), .cpuRstN(cpuRstN),
    .strapQueueN(straps[5]), .strapQuickStart(straps[4]),
    .strapGfxDisable(straps[3]), .strapLegacyMem(straps[2]),
    .strapFreqSel(straps[1]), .strapBufMode(straps[0]),
    .redirectBit(redirectBit),
    .cfgQueueN(cfgQueueN), .cfgQuickStart(cfgQuickStart),
    .cfgGfxDisable(cfgGfxDisable), .cfgLegacyMem(cfgLegacyMem),
    .cfgFreq100(cfgFreq100), .cfgMobileBuf(cfgMobileBuf),
    .addr7DriveEn(addr7DriveEn), .addr15DriveEn(addr15DriveEn),
    .gfxIsolate(gfxIsolate), .memIsolate(memIsolate), .strapError(strapError)
  );

  function automatic logic [5:0] cfgNow();
    return {cfgQueueN, cfgQuickStart, cfgGfxDisable, cfgLegacyMem, cfgFreq100, cfgMobileBuf};
  endfunction

  function automatic logic expIllegal(logic [5:0] s, logic red);
    return (s[2] && !s[3]) || (!s[2] && red);
  endfunction

  function automatic logic [1:0] expDrive(logic [5:0] s, logic win);
    return {win && !s[5], win && s[4]};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic stepNeg();
    @(negedge clk);
  endtask

  task automatic runTrial(logic [5:0] s, logic red, logic together);
    logic [5:0] other;
    logic errExp;
    sysRstN = 1'b0; cpuRstN = 1'b0; redirectBit = 1'b0; straps = s;
    repeat (4) stepNeg();
    chk("R1 cfg default", {2'b0, cfgNow()}, 8'h20);
    chk("R1 outputs quiet", {3'b0, addr7DriveEn, addr15DriveEn, gfxIsolate, memIsolate, strapError}, 8'h0);
    sysRstN = 1'b1;
    if (together) cpuRstN = 1'b1;
    stepNeg();
    chk("R2 captured straps", {2'b0, cfgNow()}, {2'b0, s});
    chk("R7 gfx isolate", {7'b0, gfxIsolate}, {7'b0, s[3] | s[2]});
    chk("R8 mem isolate", {7'b0, memIsolate}, {7'b0, s[2]});
    chk("R4 R5 drive at capture", {6'b0, addr7DriveEn, addr15DriveEn}, {6'b0, expDrive(s, 1'b1)});
    chk("R9 no error yet", {7'b0, strapError}, 8'h0);
    other = 6'($urandom);
    straps = other;
    redirectBit = red;
    errExp = expIllegal(s, red);
    stepNeg();
    chk("R9 error flag", {7'b0, strapError}, {7'b0, errExp});
    chk("R4 R5 drive in window", {6'b0, addr7DriveEn, addr15DriveEn}, {6'b0, expDrive(s, 1'b1)});
    redirectBit = 1'b0;
    if (!together) begin
      cpuRstN = 1'b1;
      for (int i = 0; i < HOLD; i++) begin
        stepNeg();
        chk("R6 hold after release", {6'b0, addr7DriveEn, addr15DriveEn}, {6'b0, expDrive(s, 1'b1)});
      end
    end
    stepNeg();
    chk("R6 window closed", {6'b0, addr7DriveEn, addr15DriveEn}, 8'h0);
    stepNeg();
    chk("R3 cfg held after strap change", {2'b0, cfgNow()}, {2'b0, s});
    chk("R9 error sticky", {7'b0, strapError}, {7'b0, errExp});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    sysRstN = 1'b0; cpuRstN = 1'b0; redirectBit = 1'b0; straps = 6'h20;
    // Directed: every strap combination, alternating release ordering
    for (int c = 0; c < 64; c++) begin
      runTrial(6'(c), 1'($urandom), 1'(c % 2));
    end
    // Directed corners: legal legacy, illegal legacy, redirect misuse
    runTrial(6'b001100, 1'b1, 1'b0);
    runTrial(6'b000100, 1'b0, 1'b1);
    runTrial(6'b100000, 1'b1, 1'b0);
    runTrial(6'b010000, 1'b0, 1'b1);
    // Random trials
    for (int t = 0; t < 40; t++) begin
      runTrial(6'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule